// File: doc/BRIEF.md
# Register access protection checker

This block guards a register space against unwanted accesses. It holds sixteen protection entries. Each entry is loaded as one 32-bit word through a simple write port. Every entry names a window of registers whose length is a power of two, and says whether reads, writes or both are refused inside that window.

Each presented access carries a register word index and a read/write flag. In the same cycle the block decides whether any enabled entry refuses it. A refused access is held back on the pass output. One clock later a registered fault pulse reports the number of the entry that refused it.

The window base is aligned down to a multiple of the window length before any comparison is made. A base that is not aligned therefore guards a shifted window, not the one that was intended.

Top module: `pt_access_guard`

## Requirements
- R1: After reset every entry is zero (disabled), `fault_valid` is low, and every access is passed.
- R2: Entry bit 29 refuses writes inside the window. An entry with only bit 29 set still passes reads there.
- R3: Entry bit 30 refuses reads inside the window. An entry with only bit 30 set still passes writes there.
- R4: Entry bits 28:24 hold L, the base-2 logarithm of the window length. The window spans 2^L registers, and accesses outside it are passed.
- R5: Entry bits 19:0 hold the base as a byte address. The register index is bits 19:2.
- R6: The low L bits of the base index are cleared before matching. For example, base index 0x07 with L=2 guards 0x04 to 0x07 and passes 0x08.
- R7: When more than one entry refuses an access, the lowest entry number is reported.
- R8: In the cycle after a refused access, `fault_valid` is high for exactly one cycle and `fault_idx` holds the entry number. A passed access or an idle cycle leaves `fault_valid` low in the next cycle.
- R9: `pass_valid` equals `acc_valid` with no refusing entry, in the same cycle as the access.
- R10: A write on the configuration port takes effect from the next cycle. An access in the same cycle is judged against the old entry. Writing a word with bits 30:29 clear disables the entry.
- R11: With L of 18 or more the window spans the whole register space.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Load an entry |
| cfg_idx | input | 4 | Entry number to load |
| cfg_data | input | 32 | Entry word |
| acc_valid | input | 1 | Access presented |
| acc_addr | input | 18 | Register word index of the access |
| acc_write | input | 1 | 1 = write, 0 = read |
| pass_valid | output | 1 | Access allowed to proceed |
| fault_valid | output | 1 | Registered refusal pulse |
| fault_idx | output | 4 | Entry that refused the access |

## Verification
On every cycle the assertions check four things:
- a loaded entry word lands in the table one cycle after the write;
- a refusal is followed by exactly one fault pulse carrying the refusing index;
- the reported index is the lowest one that refuses;
- the table is clear coming out of reset.

The window arithmetic can only be shown by the bench scenarios, with results compared against an independent model. This covers alignment of a base that is not aligned, window edges, windows covering the whole space, and read-only against write-only entries. The bench scenarios also cover the ordering of a configuration write against an access in the same cycle.

// File: rtl/pt_pkg.sv
// Package: shared constants for the access protection checker.
// Assumes: entry word layout is fixed; the register index width follows
// from the byte-address base field (bits 19:0 less the two byte bits).
package pt_pkg;
    localparam int ENTRY_W   = 32;
    localparam int NUM_ENTRIES = 16;
    localparam int IDX_W     = $clog2(NUM_ENTRIES);
    localparam int RD_BIT    = 30;
    localparam int WR_BIT    = 29;
    localparam int LOG_HI    = 28;
    localparam int LOG_LO    = 24;
    localparam int BASE_HI   = 19;
    localparam int BASE_LO   = 2;
    localparam int ADDR_W    = BASE_HI - BASE_LO + 1;
    localparam int LOG_W     = LOG_HI - LOG_LO + 1;
endpackage

// File: rtl/pt_entry_table.sv
// Module: storage for the protection entries.
// Assumes: one write per cycle; written value visible the next cycle;
// all entries clear (disabled) on reset.
module pt_entry_table
    import pt_pkg::*;
#(
    parameter int N = NUM_ENTRIES,
    parameter int IW = $clog2(N)
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          wr_en,
    input  logic [IW-1:0]                 wr_idx,
    input  logic [ENTRY_W-1:0]            wr_data,
    output logic [N-1:0][ENTRY_W-1:0]     entries
);
    // Holds each entry word; loads the addressed one on a write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            entries <= '0;
        end else if (wr_en) begin
            entries[wr_idx] <= wr_data;
        end
    end

    // R10: a loaded word is present in the table the following cycle.
    p_write_lands_r10: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> entries[$past(wr_idx)] == $past(wr_data));

    // R1: leaving reset, the table is clear.
    p_reset_clear_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> entries == '0);
endmodule

// File: rtl/pt_entry_match.sv
// Module: decides whether one entry refuses an access.
// Assumes: base is aligned down to the window length by masking the low
// L index bits; L >= ADDR_W makes the window cover the whole space.
module pt_entry_match
    import pt_pkg::*;
(
    input  logic [ENTRY_W-1:0] entry,
    input  logic [ADDR_W-1:0]  acc_addr,
    input  logic               acc_write,
    output logic               refuse
);
    logic [LOG_W-1:0]  log_len;
    logic [ADDR_W-1:0] base_idx;
    logic [ADDR_W-1:0] keep_mask;
    logic              kind_blocked;
    logic              in_window;

    // Splits the entry word and forms the window comparison.
    always_comb begin
        log_len      = entry[LOG_HI:LOG_LO];
        base_idx     = entry[BASE_HI:BASE_LO];
        keep_mask    = (32'(log_len) >= ADDR_W) ? '0
                       : ({ADDR_W{1'b1}} << log_len);
        kind_blocked = acc_write ? entry[WR_BIT] : entry[RD_BIT];
        in_window    = ((acc_addr ^ base_idx) & keep_mask) == '0;
        refuse       = kind_blocked && in_window;
    end
endmodule

// File: rtl/pt_prio_enc.sv
// Module: lowest-index priority encoder.
// Assumes: N is at least 2; idx is meaningless when any is low.
module pt_prio_enc #(
    parameter int N = 16,
    parameter int IW = $clog2(N)
) (
    input  logic [N-1:0]  vec,
    output logic          any,
    output logic [IW-1:0] idx
);
    // Scans from the top down so the lowest set bit wins.
    always_comb begin
        any = 1'b0;
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (vec[i]) begin
                any = 1'b1;
                idx = IW'(i);
            end
        end
    end
endmodule

// File: rtl/pt_access_guard.sv
// Module: top of the register access protection checker.
// Assumes: accesses are judged combinationally against the table as it
// stood at the start of the cycle; the fault report is registered.
module pt_access_guard
    import pt_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cfg_we,
    input  logic [IDX_W-1:0]   cfg_idx,
    input  logic [ENTRY_W-1:0] cfg_data,
    input  logic               acc_valid,
    input  logic [ADDR_W-1:0]  acc_addr,
    input  logic               acc_write,
    output logic               pass_valid,
    output logic               fault_valid,
    output logic [IDX_W-1:0]   fault_idx
);
    logic [NUM_ENTRIES-1:0][ENTRY_W-1:0] entries;
    logic [NUM_ENTRIES-1:0]              refuse_vec;
    logic [NUM_ENTRIES-1:0]              blk_vec;
    logic                                blk_any;
    logic [IDX_W-1:0]                    blk_idx;

    pt_entry_table #(.N(NUM_ENTRIES), .IW(IDX_W)) u_table (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (cfg_we),
        .wr_idx  (cfg_idx),
        .wr_data (cfg_data),
        .entries (entries)
    );

    for (genvar g = 0; g < NUM_ENTRIES; g++) begin : g_match
        pt_entry_match u_match (
            .entry     (entries[g]),
            .acc_addr  (acc_addr),
            .acc_write (acc_write),
            .refuse    (refuse_vec[g])
        );
    end

    // Only a presented access can be refused.
    assign blk_vec = refuse_vec & {NUM_ENTRIES{acc_valid}};

    pt_prio_enc #(.N(NUM_ENTRIES), .IW(IDX_W)) u_enc (
        .vec (blk_vec),
        .any (blk_any),
        .idx (blk_idx)
    );

    // Lets the access through when nothing refuses it.
    assign pass_valid = acc_valid && !blk_any;

    // Registers a one-cycle fault pulse with the refusing entry number.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fault_valid <= 1'b0;
            fault_idx   <= '0;
        end else begin
            fault_valid <= blk_any;
            if (blk_any) fault_idx <= blk_idx;
        end
    end

    // R8: a refusal yields a fault next cycle carrying its index.
    p_fault_after_block_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && !pass_valid) |=> (fault_valid && fault_idx == $past(blk_idx)));

    // R8: no refusal, no fault next cycle.
    p_no_spurious_fault_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !(acc_valid && !pass_valid) |=> !fault_valid);

    // R7: the reported entry refuses and no lower entry does.
    p_lowest_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
        blk_any |-> (refuse_vec[blk_idx]
                     && ((refuse_vec & ((NUM_ENTRIES'(1) << blk_idx) - 1'b1)) == '0)));
endmodule

// File: tb/tb_pt_access_guard.sv
// Bench: directed corners plus seeded random traffic against a model.
module tb_pt_access_guard;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [3:0]  cfg_idx = '0;
    logic [31:0] cfg_data = '0;
    logic        acc_valid = 1'b0;
    logic [17:0] acc_addr = '0;
    logic        acc_write = 1'b0;
    logic        pass_valid;
    logic        fault_valid;
    logic [3:0]  fault_idx;

    int checks = 0;
    int errors = 0;
    logic [31:0] model [16];

    always #10 clk = ~clk;

    pt_access_guard dut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_idx(cfg_idx),
        .cfg_data(cfg_data), .acc_valid(acc_valid), .acc_addr(acc_addr),
        .acc_write(acc_write), .pass_valid(pass_valid),
        .fault_valid(fault_valid), .fault_idx(fault_idx)
    );

    task automatic chk(input bit ok, input string req,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Model: window test by shifting both index and base right by L.
    function automatic logic [4:0] ref_judge(input logic [17:0] a, input bit wr);
        for (int i = 0; i < 16; i++) begin
            logic [31:0] w = model[i];
            int lg = int'(w[28:24]);
            logic [17:0] b = w[19:2];
            bit kind = wr ? w[29] : w[30];
            bit inwin = (lg >= 18) ? 1'b1 : ((a >> lg) == (b >> lg));
            if (kind && inwin) return {1'b1, 4'(i)};
        end
        return 5'b0;
    endfunction

    function automatic logic [31:0] mk(input bit rd, input bit wr,
                                       input int lg, input logic [17:0] idx);
        return (32'(rd) << 30) | (32'(wr) << 29) | (32'(lg & 31) << 24)
               | (32'(idx) << 2);
    endfunction

    task automatic load(input int i, input logic [31:0] w);
        @(negedge clk);
        cfg_we = 1'b1; cfg_idx = 4'(i); cfg_data = w;
        @(negedge clk);
        cfg_we = 1'b0;
        model[i] = w;
    endtask

    task automatic access(input logic [17:0] a, input bit wr, input string req,
                          input bit same_cycle_cfg = 1'b0,
                          input int ci = 0, input logic [31:0] cw = '0);
        logic [4:0] e;
        @(negedge clk);
        chk(fault_valid == 1'b0, "R8 idle", 32'(fault_valid), 0);
        acc_valid = 1'b1; acc_addr = a; acc_write = wr;
        if (same_cycle_cfg) begin
            cfg_we = 1'b1; cfg_idx = 4'(ci); cfg_data = cw;
        end
        e = ref_judge(a, wr);
        #2;
        chk(pass_valid == !e[4], {req, " R9 pass"}, 32'(pass_valid), 32'(!e[4]));
        @(negedge clk);
        acc_valid = 1'b0;
        cfg_we = 1'b0;
        if (same_cycle_cfg) model[ci] = cw;
        chk(fault_valid == e[4], {req, " R8 fault"}, 32'(fault_valid), 32'(e[4]));
        if (e[4])
            chk(fault_idx == e[3:0], {req, " R7 index"}, 32'(fault_idx), 32'(e[3:0]));
    endtask

    initial begin
        #(20 * 150000);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(1234));
        for (int i = 0; i < 16; i++) model[i] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(fault_valid == 1'b0, "R1 fault low", 32'(fault_valid), 0);
        access(18'h00000, 1'b1, "R1");
        access(18'h3FFFF, 1'b0, "R1");

        // R6 / R4: base 0x07, L=2 -> guards 0x04..0x07.
        load(5, mk(1, 1, 2, 18'h07));
        access(18'h04, 1'b0, "R6");
        access(18'h07, 1'b1, "R6");
        access(18'h08, 1'b1, "R6 R4");
        access(18'h03, 1'b0, "R4");

        // R2: write-only refusal, reads pass.
        load(3, mk(0, 1, 4, 18'h100));
        access(18'h105, 1'b0, "R2 read");
        access(18'h10F, 1'b1, "R2 write");
        access(18'h110, 1'b1, "R2 edge");

        // R3: read-only refusal, writes pass.
        load(9, mk(1, 0, 3, 18'h200));
        access(18'h207, 1'b0, "R3 read");
        access(18'h207, 1'b1, "R3 write");

        // R5: byte-address field; index 0x104 sits at byte 0x410.
        access(18'h104, 1'b1, "R5");

        // R7: entry 1 overlaps entry 3 -> 1 reported.
        load(1, mk(1, 1, 6, 18'h100));
        access(18'h101, 1'b1, "R7");

        // R10: same-cycle load judged with old value, then new value.
        access(18'h101, 1'b1, "R10 old", 1'b1, 1, 32'h0);
        access(18'h101, 1'b1, "R10 new");
        access(18'h101, 1'b0, "R10 disabled");

        // R11: L large covers everything.
        load(15, mk(0, 1, 20, 18'h00));
        access(18'h3FFFF, 1'b1, "R11");
        access(18'h3FFFF, 1'b0, "R11 read");
        load(15, 32'h0);

        // Random traffic in a small space so windows are hit often.
        for (int n = 0; n < 600; n++) begin
            if ((n % 8) == 0) begin
                int lg = ($urandom % 10 == 0) ? 18 + int'($urandom % 4)
                                              : int'($urandom % 7);
                load(int'($urandom % 16),
                     mk(1'($urandom), 1'($urandom), lg, 18'($urandom % 256)));
            end
            access(18'($urandom % 320), 1'($urandom), "R4 random");
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule